// File: doc/BRIEF.md
# Three-Wire Configuration Load Port

This block receives configuration words over a slow three-wire serial link (a serial clock, a serial data line and a load strobe) and keeps four 24-bit control registers that the rest of the chip reads in parallel. All three serial lines are sampled in the fast system clock domain. Each rising edge of the serial clock shifts one data bit into a 24-bit shift register, most significant bit first. A rising edge of the load strobe copies the shifted word into one of the four registers. The register is chosen by the two lowest bits of that same word, so the destination address travels at the tail of every word.

A chip-enable input, sampled on the system clock, holds the port inactive while it is low. It also returns every register to its power-up value and empties the shift register. The function register carries a 4-bit select field. That field drives a status output multiplexer, which routes one of eight on-chip status signals, a fixed level, or a high-impedance request to a debug pin.

Top module: `cfg3w_port`

## Requirements
- R1: After reset the registers read: reference 24'h800004 (divider field [5:2] = 1, clock-output divide code [23:20] = 8, i.e. divide by 16), fractional 24'h000001, modulation 24'h000002, function 24'h000C13 (select field [13:10] = 0011, clock-output enable bit 4 = 1). Each default carries its own address in bits [1:0].
- R2: Each rising edge of ser_clk shifts ser_data in at bit 0, most significant bit first. The bit count is not checked: a load uses the last 24 bits shifted in.
- R3: A rising edge of ser_le writes the shifted word to exactly one register, chosen by word bits [1:0]: 00 reference, 01 fractional, 10 modulation, 11 function. The other three registers keep their contents.
- R4: A load is visible on the register outputs after the third system clock rising edge that follows ser_le going high, and not after the second. A falling ser_le changes nothing, and the registers are stable when no load occurs.
- R5: While chip_en is low, every register holds its R1 default and the shift register holds zero. Serial clock and load edges have no effect during that time.
- R6: When a ser_clk rising edge and a ser_le rising edge are detected in the same cycle, the load takes the word as it stood before that bit, and the bit is then shifted in.
- R7: The function register select field [13:10] drives mux_o as follows. 0000 gives low and 0001 gives high. 0011 regulator ready, 0100 digital lock, 0101 analog lock, 0110 R divider/2, 0111 N divider/2, 1000 R divider, 1001 N divider, 1010 data-rate clock. Codes 1011 to 1111 give low.
- R8: Select code 0010 drives mux_oe_o low with mux_o low. Every other code drives mux_oe_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable; low clears registers to defaults |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data (asynchronous) |
| ser_le | input | 1 | Serial load strobe (asynchronous) |
| st_reg_ready | input | 1 | Regulator ready status |
| st_dig_lock | input | 1 | Digital lock detect status |
| st_ana_lock | input | 1 | Analog lock detect status |
| st_rdiv_half | input | 1 | R divider output halved |
| st_ndiv_half | input | 1 | N divider output halved |
| st_rdiv | input | 1 | R divider output |
| st_ndiv | input | 1 | N divider output |
| st_data_rate | input | 1 | Data-rate clock |
| ref_word_o | output | 24 | Reference register contents |
| frac_word_o | output | 24 | Fractional register contents |
| mod_word_o | output | 24 | Modulation register contents |
| func_word_o | output | 24 | Function register contents |
| mux_o | output | 1 | Status multiplexer output |
| mux_oe_o | output | 1 | Status output enable (low = high impedance) |

## Verification
A shift and a load can land in the same system cycle when the serial clock and the load strobe rise together. Both pass through synchronizers of equal depth, so their edges are detected in the same cycle. The bench provokes this by raising both lines at the same instant on the 25th bit. It judges the first load against the 24 bits sent before that bit. A second, bare load pulse must then deliver the word with the extra bit appended, which sends it to a different register.

// File: rtl/cfg3w_pkg.sv
`timescale 1ns/1ps
package cfg3w_pkg;
    localparam int WORD_W     = 24;
    localparam int ADDR_W     = 2;
    localparam int NUM_REGS   = 1 << ADDR_W;
    localparam int SEL_W      = 4;
    localparam int SEL_LSB    = 10;
    localparam int NUM_STATUS = 8;
    localparam int RDIV_LSB   = 2;
    localparam int RDIV_W     = 4;
    localparam int CKDIV_W    = 4;
    localparam int CKDIV_LSB  = WORD_W - CKDIV_W;
    localparam int CKEN_BIT   = 4;

    localparam int IDX_REF  = 0;
    localparam int IDX_FRAC = 1;
    localparam int IDX_MOD  = 2;
    localparam int IDX_FUNC = 3;

    typedef logic [WORD_W-1:0] word_t;

    localparam logic [SEL_W-1:0] MSEL_LOW       = 4'd0;
    localparam logic [SEL_W-1:0] MSEL_HIGH      = 4'd1;
    localparam logic [SEL_W-1:0] MSEL_HIZ       = 4'd2;
    localparam logic [SEL_W-1:0] MSEL_REG_READY = 4'd3;
    localparam logic [SEL_W-1:0] MSEL_DIG_LOCK  = 4'd4;
    localparam logic [SEL_W-1:0] MSEL_ANA_LOCK  = 4'd5;
    localparam logic [SEL_W-1:0] MSEL_RDIV_HALF = 4'd6;
    localparam logic [SEL_W-1:0] MSEL_NDIV_HALF = 4'd7;
    localparam logic [SEL_W-1:0] MSEL_RDIV      = 4'd8;
    localparam logic [SEL_W-1:0] MSEL_NDIV      = 4'd9;
    localparam logic [SEL_W-1:0] MSEL_RATE      = 4'd10;

    typedef struct packed {
        logic data_rate;
        logic ndiv;
        logic rdiv;
        logic ndiv_half;
        logic rdiv_half;
        logic ana_lock;
        logic dig_lock;
        logic reg_ready;
    } status_t;

    // Power-up content of register idx; each word carries its own address.
    function automatic word_t reg_default(int idx);
        word_t w;
        w = '0;
        w[ADDR_W-1:0] = ADDR_W'(idx);
        case (idx)
            IDX_REF: begin
                w[RDIV_LSB +: RDIV_W]   = RDIV_W'(1);
                w[CKDIV_LSB +: CKDIV_W] = CKDIV_W'(8);
            end
            IDX_FUNC: begin
                w[SEL_LSB +: SEL_W] = MSEL_REG_READY;
                w[CKEN_BIT]         = 1'b1;
            end
            default: ;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/cfg3w_sync.sv
`timescale 1ns/1ps
module cfg3w_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]             prev;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl_o  = s_q.chain[STAGES-1];
    assign rise_o = s_q.chain[STAGES-1] & ~s_q.prev;
endmodule

// File: rtl/cfg3w_shifter.sv
`timescale 1ns/1ps
module cfg3w_shifter
    import cfg3w_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  chip_en,
    input  logic  shift_en,
    input  logic  bit_i,
    output word_t word_o
);
    typedef struct packed {
        word_t sr;
    } shf_st_t;

    shf_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!chip_en) begin
            s_d.sr = '0;
        end else if (shift_en) begin
            s_d.sr = {s_q.sr[WORD_W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Registered value: a load in the same cycle as a shift sees the old word.
    assign word_o = s_q.sr;
endmodule

// File: rtl/cfg3w_regbank.sv
`timescale 1ns/1ps
module cfg3w_regbank
    import cfg3w_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     chip_en,
    input  logic                     load_en,
    input  word_t                    word_i,
    output logic [NUM_REGS-1:0][WORD_W-1:0] regs_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        word_t val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (!chip_en) begin
                val_d = reg_default(g);
            end else if (load_en && (word_i[ADDR_W-1:0] == ADDR_W'(g))) begin
                val_d = word_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= reg_default(g);
            else        val_q <= val_d;
        end

        assign regs_o[g] = val_q;
    end
endmodule

// File: rtl/cfg3w_statmux.sv
`timescale 1ns/1ps
module cfg3w_statmux
    import cfg3w_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    input  status_t          st_i,
    output logic             out_o,
    output logic             oe_o
);
    always_comb begin
        out_o = 1'b0;
        oe_o  = 1'b1;
        case (sel_i)
            MSEL_LOW:       out_o = 1'b0;
            MSEL_HIGH:      out_o = 1'b1;
            MSEL_HIZ:       oe_o  = 1'b0;
            MSEL_REG_READY: out_o = st_i.reg_ready;
            MSEL_DIG_LOCK:  out_o = st_i.dig_lock;
            MSEL_ANA_LOCK:  out_o = st_i.ana_lock;
            MSEL_RDIV_HALF: out_o = st_i.rdiv_half;
            MSEL_NDIV_HALF: out_o = st_i.ndiv_half;
            MSEL_RDIV:      out_o = st_i.rdiv;
            MSEL_NDIV:      out_o = st_i.ndiv;
            MSEL_RATE:      out_o = st_i.data_rate;
            default:        out_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfg3w_port.sv
`timescale 1ns/1ps
module cfg3w_port
    import cfg3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    input  logic              st_reg_ready,
    input  logic              st_dig_lock,
    input  logic              st_ana_lock,
    input  logic              st_rdiv_half,
    input  logic              st_ndiv_half,
    input  logic              st_rdiv,
    input  logic              st_ndiv,
    input  logic              st_data_rate,
    output logic [WORD_W-1:0] ref_word_o,
    output logic [WORD_W-1:0] frac_word_o,
    output logic [WORD_W-1:0] mod_word_o,
    output logic [WORD_W-1:0] func_word_o,
    output logic              mux_o,
    output logic              mux_oe_o
);
    localparam int LN_DATA = 0;
    localparam int LN_CLK  = 1;
    localparam int LN_LE   = 2;
    localparam int LANES   = 3;

    logic [LANES-1:0] ser_lvl, ser_rise;
    logic             clk_rise, le_rise, data_bit;
    word_t            shift_word;
    logic [NUM_REGS-1:0][WORD_W-1:0] regs;
    logic [SEL_W-1:0] mux_sel;
    status_t          status;
    logic             unused_sync;

    cfg3w_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_le, ser_clk, ser_data}),
        .lvl_o   (ser_lvl),
        .rise_o  (ser_rise)
    );

    assign data_bit    = ser_lvl[LN_DATA];
    assign clk_rise    = ser_rise[LN_CLK];
    assign le_rise     = ser_rise[LN_LE];
    assign unused_sync = ^{ser_rise[LN_DATA], ser_lvl[LN_CLK], ser_lvl[LN_LE]};

    cfg3w_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .chip_en  (chip_en),
        .shift_en (clk_rise),
        .bit_i    (data_bit),
        .word_o   (shift_word)
    );

    cfg3w_regbank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .chip_en (chip_en),
        .load_en (le_rise),
        .word_i  (shift_word),
        .regs_o  (regs)
    );

    assign ref_word_o  = regs[IDX_REF];
    assign frac_word_o = regs[IDX_FRAC];
    assign mod_word_o  = regs[IDX_MOD];
    assign func_word_o = regs[IDX_FUNC];

    assign mux_sel = regs[IDX_FUNC][SEL_LSB +: SEL_W];

    always_comb begin
        status.reg_ready = st_reg_ready;
        status.dig_lock  = st_dig_lock;
        status.ana_lock  = st_ana_lock;
        status.rdiv_half = st_rdiv_half;
        status.ndiv_half = st_ndiv_half;
        status.rdiv      = st_rdiv;
        status.ndiv      = st_ndiv;
        status.data_rate = st_data_rate;
    end

    cfg3w_statmux u_mux (
        .sel_i (mux_sel),
        .st_i  (status),
        .out_o (mux_o),
        .oe_o  (mux_oe_o)
    );
endmodule

// File: rtl/cfg3w_port_chk.sv
`timescale 1ns/1ps
module cfg3w_port_chk
    import cfg3w_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              chip_en,
    input logic              le_rise,
    input logic [WORD_W-1:0] ref_word,
    input logic [WORD_W-1:0] frac_word,
    input logic [WORD_W-1:0] mod_word,
    input logic [WORD_W-1:0] func_word,
    input logic [SEL_W-1:0]  mux_sel,
    input logic              mux_o,
    input logic              mux_oe_o,
    input logic              st_reg_ready
);
    p_stable_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chip_en) && !$past(le_rise)) |->
            ($stable(ref_word) && $stable(frac_word) && $stable(mod_word) && $stable(func_word)));

    p_ce_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> (ref_word == reg_default(IDX_REF) && frac_word == reg_default(IDX_FRAC) &&
                      mod_word == reg_default(IDX_MOD) && func_word == reg_default(IDX_FUNC)));

    p_single_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chip_en) |->
            ($countones({ref_word != $past(ref_word), frac_word != $past(frac_word),
                         mod_word != $past(mod_word), func_word != $past(func_word)}) <= 1));

    p_ref_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_word != $past(ref_word)) |-> (ref_word[ADDR_W-1:0] == 2'b00));
    p_frac_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frac_word != $past(frac_word)) |-> (frac_word[ADDR_W-1:0] == 2'b01));
    p_mod_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_word != $past(mod_word)) |-> (mod_word[ADDR_W-1:0] == 2'b10));
    p_func_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (func_word != $past(func_word)) |-> (func_word[ADDR_W-1:0] == 2'b11));

    p_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_sel == MSEL_HIZ) |-> (!mux_oe_o && !mux_o));
    p_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_sel != MSEL_HIZ) |-> mux_oe_o);

    p_ready_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_sel == MSEL_REG_READY) |-> (mux_o == st_reg_ready));
endmodule

bind cfg3w_port cfg3w_port_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chip_en      (chip_en),
    .le_rise      (le_rise),
    .ref_word     (ref_word_o),
    .frac_word    (frac_word_o),
    .mod_word     (mod_word_o),
    .func_word    (func_word_o),
    .mux_sel      (mux_sel),
    .mux_o        (mux_o),
    .mux_oe_o     (mux_oe_o),
    .st_reg_ready (st_reg_ready)
);

// File: tb/cfg3w_port_tb_top.sv
`timescale 1ns/1ps
module cfg3w_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chip_en = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [7:0] st_vec = 8'h00;
    logic [23:0] ref_w, frac_w, mod_w, func_w;
    logic mux_o, mux_oe_o;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cfg3w_port dut_i (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .st_reg_ready(st_vec[0]), .st_dig_lock(st_vec[1]), .st_ana_lock(st_vec[2]),
        .st_rdiv_half(st_vec[3]), .st_ndiv_half(st_vec[4]), .st_rdiv(st_vec[5]),
        .st_ndiv(st_vec[6]), .st_data_rate(st_vec[7]),
        .ref_word_o(ref_w), .frac_word_o(frac_w), .mod_word_o(mod_w), .func_word_o(func_w),
        .mux_o(mux_o), .mux_oe_o(mux_oe_o)
    );

    localparam logic [23:0] DEF_REF  = 24'h800004;
    localparam logic [23:0] DEF_FRAC = 24'h000001;
    localparam logic [23:0] DEF_MOD  = 24'h000002;
    localparam logic [23:0] DEF_FUNC = 24'h000C13;

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_data = b;
        ser_clk  = 1'b0;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_le();
        @(negedge clk);
        ser_le = 1'b1;
        repeat (4) @(negedge clk);
        ser_le = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic write_word(input logic [23:0] w);
        send_bits({8'h00, w}, 24);
        pulse_le();
    endtask

    task automatic t_reset();
        check("R1 ref default", ref_w, DEF_REF);
        check("R1 frac default", frac_w, DEF_FRAC);
        check("R1 mod default", mod_w, DEF_MOD);
        check("R1 func default", func_w, DEF_FUNC);
        st_vec = 8'h01;
        @(negedge clk);
        check("R7 default select routes ready", {23'd0, mux_o}, 24'd1);
        st_vec = 8'hFE;
        @(negedge clk);
        check("R7 default select ready low", {23'd0, mux_o}, 24'd0);
        st_vec = 8'h00;
    endtask

    task automatic t_load_each();
        write_word(24'h5A3C78);
        check("R3 ref loaded", ref_w, 24'h5A3C78);
        check("R3 frac untouched", frac_w, DEF_FRAC);
        write_word(24'h1234A5);
        check("R3 frac loaded", frac_w, 24'h1234A5);
        check("R3 ref kept", ref_w, 24'h5A3C78);
        write_word(24'hC0FFEE);
        check("R3 mod loaded", mod_w, 24'hC0FFEE);
        check("R3 func untouched", func_w, DEF_FUNC);
        write_word(24'h00C3F7);
        check("R3 func loaded", func_w, 24'h00C3F7);
        check("R3 mod kept", mod_w, 24'hC0FFEE);
    endtask

    task automatic t_overlong();
        send_bits(32'h0000000F, 4);
        send_bits({8'h00, 24'h00FF01}, 24);
        pulse_le();
        check("R2 last 24 bits loaded", frac_w, 24'h00FF01);
    endtask

    task automatic t_latency();
        send_bits({8'h00, 24'hABCDE1}, 24);
        repeat (3) @(negedge clk);
        ser_le = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R4 not yet after second edge", frac_w, 24'h00FF01);
        @(posedge clk);
        @(negedge clk);
        check("R4 visible after third edge", frac_w, 24'hABCDE1);
        repeat (3) @(negedge clk);
        send_bits({8'h00, 24'h777772}, 24);
        ser_le = 1'b0;
        repeat (6) @(negedge clk);
        check("R4 falling strobe ignored (mod)", mod_w, 24'hC0FFEE);
        check("R4 falling strobe ignored (frac)", frac_w, 24'hABCDE1);
    endtask

    task automatic t_mux();
        for (int code = 0; code < 16; code++) begin
            logic [7:0] pat;
            logic exp_a, exp_b, exp_oe;
            write_word({10'd0, code[3:0], 10'h003});
            exp_oe = (code != 2);
            if (code >= 3 && code <= 10) begin
                pat   = 8'h01 << (code - 3);
                exp_a = 1'b1;
                exp_b = 1'b0;
            end else if (code == 1) begin
                pat = 8'h00; exp_a = 1'b1; exp_b = 1'b1;
            end else begin
                pat = 8'hFF; exp_a = 1'b0; exp_b = 1'b0;
            end
            st_vec = pat;
            @(negedge clk);
            check((code == 2) ? "R8 oe code" : "R7 output pattern A", {23'd0, mux_o}, {23'd0, exp_a});
            check("R8 output enable", {23'd0, mux_oe_o}, {23'd0, exp_oe});
            st_vec = ~pat;
            @(negedge clk);
            check((code == 2) ? "R8 out low when hiz" : "R7 output pattern B", {23'd0, mux_o}, {23'd0, exp_b});
            check("R8 output enable B", {23'd0, mux_oe_o}, {23'd0, exp_oe});
        end
        st_vec = 8'h00;
    endtask

    task automatic t_chip_en();
        write_word(24'h5A3C78);
        write_word(24'h246812);
        @(negedge clk);
        chip_en = 1'b0;
        repeat (2) @(negedge clk);
        write_word(24'h13579C);
        check("R5 ref default while disabled", ref_w, DEF_REF);
        check("R5 frac default while disabled", frac_w, DEF_FRAC);
        check("R5 mod default while disabled", mod_w, DEF_MOD);
        check("R5 func default while disabled", func_w, DEF_FUNC);
        chip_en = 1'b1;
        repeat (2) @(negedge clk);
        pulse_le();
        check("R5 shift register emptied", ref_w, 24'h000000);
    endtask

    task automatic t_coincide();
        logic [23:0] w1, w2;
        w1 = 24'h3C5A91;
        w2 = {w1[22:0], 1'b0};
        send_bits({8'h00, w1}, 24);
        @(negedge clk);
        ser_data = 1'b0;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        ser_le  = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
        ser_le  = 1'b0;
        repeat (4) @(negedge clk);
        check("R6 load takes pre-shift word", frac_w, w1);
        check("R6 mod untouched by joint edge", mod_w, DEF_MOD);
        pulse_le();
        check("R6 extra bit shifted after load", mod_w, w2);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_load_each();
        t_overlong();
        t_latency();
        t_mux();
        t_chip_en();
        t_coincide();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule